// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a device that carries a boundary-scan chain. A sixteen-state controller, stepped by the mode-select input on each rising test-clock edge, moves through the data-register and instruction-register scan paths. A 3-bit instruction chooses which data register lies between serial input and serial output. There are three choices: a one-bit bypass stage, a 32-bit identification word, or a 69-bit boundary register. The boundary register takes a parallel snapshot of the device pins at capture time.

The instruction set is reduced. No opcode drives or preloads the pins from the chain. The external-test and sample/preload opcodes only capture a snapshot, and their update step does nothing. One dedicated sampling opcode also asks the functional core to put its outputs into high impedance. Serial data enters at the most significant bit of the selected register. It leaves from the least significant bit, and the serial output is relaunched on the falling test-clock edge.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `rst_n` is low at rising and falling test-clock edges, the controller goes to Test-Logic-Reset. In that state `tdo_oe` and `out_hiz_req` are 0 and the active instruction is IDCODE (001).
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state. This restores IDCODE as the active instruction.
- R3: State changes follow the standard sixteen-state scan graph, sampling `tms` on the rising edge. A scan that passes through Exit1, Pause and Exit2 and returns to Shift continues shifting the same register without recapture.
- R4: In Capture-IR the instruction shift stage loads 001: bit 0 is 1, bit 1 is 0 and bit 2 is 0. In Shift-IR, `tdi` enters bit 2 and `tdo` presents bit 0.
- R5: The instruction shifted in becomes active on the falling test-clock edge in Update-IR. Before then, including throughout Shift-IR, the previous instruction stays in force.
- R6: Under IDCODE (001), Capture-DR loads the 32-bit word {revision[31:29], part[28:12], vendor[11:1], 1'b1}, and bit 0 is shifted out first.
- R7: Under 000, 010 and 100, Capture-DR loads the 69-bit `pin_snap` into the boundary register, which shifts out from bit 0.
- R8: Update-DR under any capture opcode has no effect: `out_hiz_req` keeps its value, and the next capture again reflects `pin_snap`.
- R9: Opcode 111 and the unused codes 011, 101 and 110 select a single bypass stage that captures 0. The first bit out is 0, followed by `tdi` delayed one clock.
- R10: `out_hiz_req` is 1 exactly while 010 is the active instruction. External-test (000) never raises it.
- R11: `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR. `tdo` and `tdo_oe` change on the falling test-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| pin_snap | input | 69 | Parallel pin snapshot for the boundary register |
| tdo | output | 1 | Serial data out, launched on falling edge |
| tdo_oe | output | 1 | Serial output enable |
| out_hiz_req | output | 1 | Request to the functional core to tri-state its outputs |

## Verification
A wrong controller state shows up within one test clock. Either `tdo_oe` switches in the wrong cycle, or the first bit of a scan comes from the wrong register: the bypass 0 appears instead of the identification bit 1, or the reverse. A corrupted instruction shift stage changes the 1,0,0 capture pattern on the first three Shift-IR bits. An instruction that takes effect at the wrong moment shows on `out_hiz_req` during Shift-IR or on the half cycle after Update-IR. A wrong capture source or shift direction changes every bit of the 32- or 69-bit scan that follows. A reset path that misses is exposed at the first identification scan after five high mode-select cycles.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/100ps
// Shared types for the scan port: controller state encoding,
// instruction codes and data-register selection.
package scan_tap_pkg;
    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] OP_EXTEST   = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE   = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE_Z = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS   = 3'b111;

    typedef enum logic [1:0] {DSEL_BYPASS, DSEL_ID, DSEL_BOUNDARY} dr_sel_t;
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/100ps
// Sixteen-state scan controller. Advances on each rising test-clock
// edge according to tms. Assumes rst_n is sampled synchronously.
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);
    tap_state_t nxt;

    // Next-state graph driven by tms.
    always_comb begin
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/100ps
// Instruction path: a shift stage captured and shifted on rising edges,
// and an active instruction loaded on the falling edge in Update-IR.
// Decodes the data-register selection and the tri-state request.
module tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_state_t      state,
    output logic [IR_W-1:0] ir_sr,
    output logic [IR_W-1:0] ir_q,
    output dr_sel_t         dr_sel,
    output logic            hiz_req
);
    localparam logic [IR_W-1:0] CAP_PATTERN = {{(IR_W-2){1'b0}}, 2'b01};

    // Shift stage: fixed capture pattern, then serial shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                  ir_sr <= '0;
        else if (state == ST_CAP_IR) ir_sr <= CAP_PATTERN;
        else if (state == ST_SHF_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Active instruction: reset to IDCODE, loaded on the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n || state == ST_RESET) ir_q <= OP_IDCODE;
        else if (state == ST_UPD_IR)     ir_q <= ir_sr;
    end

    // Opcode decode; unused codes fall back to bypass.
    always_comb begin
        unique case (ir_q)
            OP_IDCODE:                        dr_sel = DSEL_ID;
            OP_EXTEST, OP_SAMPLE_Z, OP_SAMPLE: dr_sel = DSEL_BOUNDARY;
            default:                          dr_sel = DSEL_BYPASS;
        endcase
    end

    assign hiz_req = (ir_q == OP_SAMPLE_Z);
endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/100ps
// Data registers: bypass stage, identification word and boundary
// snapshot. Only the selected one captures and shifts. Update-DR
// drives nothing, since no opcode loads the pins.
module tap_dr
    import scan_tap_pkg::*;
#(
    parameter int          BSR_W    = 69,
    parameter int          ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tdi,
    input  tap_state_t       state,
    input  dr_sel_t          dr_sel,
    input  logic [BSR_W-1:0] pin_snap,
    output logic             dr_lsb
);
    logic             byp_q;
    logic [ID_W-1:0]  id_q;
    logic [BSR_W-1:0] bsr_q;

    logic cap, shf;
    assign cap = (state == ST_CAP_DR);
    assign shf = (state == ST_SHF_DR);

    // Bypass stage: captures 0, shifts tdi.
    always_ff @(posedge tck) begin
        if (!rst_n)                           byp_q <= 1'b0;
        else if (dr_sel == DSEL_BYPASS && cap) byp_q <= 1'b0;
        else if (dr_sel == DSEL_BYPASS && shf) byp_q <= tdi;
    end

    // Identification word: captures the fixed value, shifts toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                        id_q <= '0;
        else if (dr_sel == DSEL_ID && cap) id_q <= ID_VALUE;
        else if (dr_sel == DSEL_ID && shf) id_q <= {tdi, id_q[ID_W-1:1]};
    end

    // Boundary register: captures the pin snapshot, shifts toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                              bsr_q <= '0;
        else if (dr_sel == DSEL_BOUNDARY && cap) bsr_q <= pin_snap;
        else if (dr_sel == DSEL_BOUNDARY && shf) bsr_q <= {tdi, bsr_q[BSR_W-1:1]};
    end

    // Serial output of the selected register.
    always_comb begin
        unique case (dr_sel)
            DSEL_ID:       dr_lsb = id_q[0];
            DSEL_BOUNDARY: dr_lsb = bsr_q[0];
            default:       dr_lsb = byp_q;
        endcase
    end
endmodule

// File: rtl/scan_tap_ctrl.sv
`timescale 1ns/100ps
// Top of the scan port: controller, instruction path and data
// registers. The serial output and its enable are relaunched on the
// falling edge. Assumes a free-running tck during rst_n.
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter int REV_W    = 3,
    parameter int PART_W   = 17,
    parameter int VENDOR_W = 11,
    parameter int BSR_W    = 69,
    parameter logic [REV_W-1:0]    REV_CODE    = 3'd2,
    parameter logic [PART_W-1:0]   PART_CODE   = 17'h0B3C5,
    parameter logic [VENDOR_W-1:0] VENDOR_CODE = 11'h1A7
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BSR_W-1:0] pin_snap,
    output logic             tdo,
    output logic             tdo_oe,
    output logic             out_hiz_req
);
    localparam int ID_W = REV_W + PART_W + VENDOR_W + 1;
    localparam logic [ID_W-1:0] ID_VALUE = {REV_CODE, PART_CODE, VENDOR_CODE, 1'b1};

    tap_state_t      state;
    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;
    dr_sel_t         dr_sel;
    logic            dr_lsb;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck     (tck),
        .rst_n   (rst_n),
        .tdi     (tdi),
        .state   (state),
        .ir_sr   (ir_sr),
        .ir_q    (ir_q),
        .dr_sel  (dr_sel),
        .hiz_req (out_hiz_req)
    );

    tap_dr #(
        .BSR_W    (BSR_W),
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck      (tck),
        .rst_n    (rst_n),
        .tdi      (tdi),
        .state    (state),
        .dr_sel   (dr_sel),
        .pin_snap (pin_snap),
        .dr_lsb   (dr_lsb)
    );

    // Falling-edge launch of serial data and its enable.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
            if (state == ST_SHF_IR)      tdo <= ir_sr[0];
            else if (state == ST_SHF_DR) tdo <= dr_lsb;
            else                         tdo <= 1'b0;
        end
    end
endmodule

// File: rtl/tap_checker.sv
`timescale 1ns/100ps
// Temporal checks on the scan port, attached to the top by bind.
// All properties are sampled on the rising test-clock edge.
module tap_checker
    import scan_tap_pkg::*;
(
    input logic       tck,
    input logic       rst_n,
    input logic       tms,
    input tap_state_t state,
    input logic [2:0] ir_sr,
    input logic [2:0] ir_q,
    input logic       tdo_oe,
    input logic       out_hiz_req
);
    logic [2:0] ones_cnt;

    // Counts consecutive high tms samples, saturating at five.
    always_ff @(posedge tck) begin
        if (!rst_n)             ones_cnt <= '0;
        else if (!tms)          ones_cnt <= '0;
        else if (ones_cnt != 5) ones_cnt <= ones_cnt + 3'd1;
    end

    // R2: five high tms edges leave the controller in reset.
    a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_cnt == 3'd5) |-> (state == ST_RESET));

    // R4: capture-IR loads 01 into the two low bits.
    a_r4_capture_pattern: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(state) == ST_CAP_IR) |-> (ir_sr[1:0] == 2'b01));

    // R5: active instruction moves only in Update-IR or reset.
    a_r5_ir_changes_at_update: assert property (@(posedge tck) disable iff (!rst_n)
        !$stable(ir_q) |-> (state == ST_UPD_IR || state == ST_RESET));

    // R10: tri-state request rises only after an Update-IR.
    a_r10_hiz_rises_on_update: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(out_hiz_req) |-> (state == ST_UPD_IR));

    // R11: output enable tracks the shift states.
    a_r11_oe_in_shift: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe == (state == ST_SHF_IR || state == ST_SHF_DR));
endmodule

bind scan_tap_ctrl tap_checker u_chk (
    .tck         (tck),
    .rst_n       (rst_n),
    .tms         (tms),
    .state       (state),
    .ir_sr       (ir_sr),
    .ir_q        (ir_q),
    .tdo_oe      (tdo_oe),
    .out_hiz_req (out_hiz_req)
);

// File: tb/scan_tap_ctrl_test.sv
`timescale 1ns/100ps
// Scoreboard bench: driver tasks queue the expected serial bits, and a
// monitor pops and compares them against tdo while shifting.
module scan_tap_ctrl_test;
    localparam int BSR_W = 69;
    localparam logic [31:0] EXP_ID = {3'd2, 17'h0B3C5, 11'h1A7, 1'b1};

    typedef struct {
        logic  v;
        string tag;
    } exp_t;

    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [BSR_W-1:0] pin_snap;
    logic tdo, tdo_oe, out_hiz_req;

    exp_t exp_q[$];
    logic mon_en = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    logic cur_hiz = 1'b0;

    scan_tap_ctrl uut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi),
        .pin_snap(pin_snap), .tdo(tdo), .tdo_oe(tdo_oe), .out_hiz_req(out_hiz_req)
    );

    always #2 tck = ~tck;

    function automatic void check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endfunction

    // Monitor: samples tdo just before each rising edge of a shift step.
    always @(negedge tck) begin
        #1.5;
        if (mon_en) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL %s: actual %b expected queued bit", "scoreboard", tdo);
            end else begin
                e = exp_q.pop_front();
                check(tdo, e.v, e.tag);
                check(tdo_oe, 1'b1, "R11");
            end
        end
    end

    task automatic step(input logic m, input logic d);
        @(negedge tck); #1;
        tms = m; tdi = d; mon_en = 1'b0;
    endtask

    task automatic shift_step(input logic m, input logic d, input logic e, input string tag);
        exp_t it;
        @(negedge tck); #1;
        tms = m; tdi = d;
        it.v = e; it.tag = tag;
        exp_q.push_back(it);
        mon_en = 1'b1;
    endtask

    // Loads an opcode from Run-Test/Idle and back; checks capture and timing.
    task automatic load_ir(input logic [2:0] op);
        logic cap[3];
        logic nh;
        cap[0] = 1'b1; cap[1] = 1'b0; cap[2] = 1'b0;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            shift_step(i == 2, op[i], cap[i], "R4");
            #0.6 check(out_hiz_req, cur_hiz, "R5");
        end
        step(1, 0);                 // into Update-IR at next rising edge
        #0.6 check(out_hiz_req, cur_hiz, "R5");
        step(0, 0);                 // falling edge in Update-IR has passed
        nh = (op == 3'b010);
        check(out_hiz_req, nh, "R5");
        check(out_hiz_req, nh, "R10");
        cur_hiz = nh;
    endtask

    // Scans n bits through the data path from Run-Test/Idle and back.
    task automatic scan_dr(input int n, input logic [127:0] din,
                           input logic [127:0] exp, input string tag);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) shift_step(i == n - 1, din[i], exp[i], tag);
        step(1, 0); step(0, 0);
        #0.6 check(tdo_oe, 1'b0, "R11");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] d, e;
        pin_snap = {1'b1, 68'h1_2345_6789_ABCD_EF0};
        repeat (4) @(negedge tck);
        #1 check(tdo_oe, 1'b0, "R1");
        check(out_hiz_req, 1'b0, "R1");
        rst_n = 1'b1;
        step(0, 0);                               // to Run-Test/Idle

        // R1 and R6: identification word is active after reset.
        scan_dr(32, 128'h0, {96'h0, EXP_ID}, "R6");

        // R3: scan split by Pause-DR continues the same register.
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 10; i++) shift_step(i == 9, 1'b0, EXP_ID[i], "R3");
        step(0, 0);                               // Exit1 -> Pause
        step(0, 0);
        #0.6 check(tdo_oe, 1'b0, "R11");
        step(1, 0);                               // Pause -> Exit2
        step(0, 0);                               // Exit2 -> Shift
        for (int i = 10; i < 32; i++) shift_step(i == 31, 1'b0, EXP_ID[i], "R3");
        step(1, 0); step(0, 0);

        // R9: bypass opcode.
        load_ir(3'b111);
        d = 128'hB2; e = {d[126:0], 1'b0};
        scan_dr(8, d, e, "R9");

        // R9: unused code behaves as bypass.
        load_ir(3'b101);
        d = 128'h5C; e = {d[126:0], 1'b0};
        scan_dr(8, d, e, "R9");

        // R7: sample/preload captures the snapshot.
        load_ir(3'b100);
        scan_dr(BSR_W, 128'h0, {59'h0, pin_snap}, "R7");

        // R8: update under sample changes nothing visible.
        d = {59'h0, ~pin_snap};
        scan_dr(BSR_W, d, {59'h0, pin_snap}, "R8");
        check(out_hiz_req, 1'b0, "R8");
        pin_snap = {1'b0, 68'hF_EDCB_A987_6543_210};
        scan_dr(BSR_W, 128'h0, {59'h0, pin_snap}, "R8");

        // R7 and R10: external-test captures, never tri-states.
        load_ir(3'b000);
        scan_dr(BSR_W, 128'h0, {59'h0, pin_snap}, "R7");
        check(out_hiz_req, 1'b0, "R10");

        // R10: sample-with-high-Z captures and raises the request.
        load_ir(3'b010);
        pin_snap = {1'b1, 68'h0_F0F0_3C3C_A5A5_99C};
        scan_dr(BSR_W, 128'h0, {59'h0, pin_snap}, "R7");
        check(out_hiz_req, 1'b1, "R10");

        // R2: five high tms edges from inside Shift-DR.
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        check(out_hiz_req, 1'b0, "R2");
        cur_hiz = 1'b0;
        scan_dr(32, 128'h0, {96'h0, EXP_ID}, "R2");

        // R1: reset asserted mid-run restores identification.
        load_ir(3'b111);
        step(0, 0);
        rst_n = 1'b0;
        step(0, 0); step(0, 0);
        check(tdo_oe, 1'b0, "R1");
        rst_n = 1'b1;
        step(0, 0);
        scan_dr(32, 128'h0, {96'h0, EXP_ID}, "R1");

        repeat (3) @(negedge tck);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule